// File: doc/BRIEF.md
# SMBus Configuration Register Slave

This block is a two-wire serial slave that exposes a bank of byte-wide configuration registers to a bus master. It samples the bus clock and data lines with a fast system clock. It recognises start, repeated start and stop conditions and matches a 7-bit device address. It acknowledges each byte it accepts and pulls the data line low through an open-drain enable. Every register is presented in parallel on a flat output bus so that surrounding logic can use the settings directly. Every write that reaches an implemented register also produces a one-cycle strobe carrying the register index and the data byte.

The command byte that follows the address picks the access type. With its top bit set, the low seven bits give a register offset. Data bytes then go to that offset and the offsets after it, which covers single-byte and low/high word transfers. With its top bit clear, the transfer is a counted block that always starts at register 0. A block write carries a length byte first. A block read returns the register count first and then the register contents.

A few registers are special. One register holds strap inputs captured during reset in its upper bits. One register is a constant identification byte. One register holds a status flag that is set by an event input and is cleared by writing 1 to it.

Top module: `smb_regbank`

## Requirements
- R1: The slave acknowledges an address byte only when its upper seven bits equal `DEV_ADDR`. On any other address it leaves the data line released for the acknowledge bit and ignores the bus until the next start, so no register changes.
- R2: Command bit 7 = 1 selects indexed access, and command bits 6:0 give the offset. A following data byte is written to that offset, and `wr_stb_o` pulses with `wr_idx_o` set to the offset and `wr_data_o` set to the byte.
- R3: In indexed access, the first data byte goes to the offset and the second to offset+1 (word write). An indexed read returns the register at the offset and then the one at offset+1, for as long as the master acknowledges.
- R4: Command bit 7 = 0 selects block access, and command bits 6:0 are ignored. A block write sends a length byte and then data bytes that land in registers 0, 1, 2 and so on, in that order.
- R5: In a block write, data bytes beyond the length byte are acknowledged and discarded. A stop after any complete byte leaves the later registers unchanged.
- R6: A block read returns the register count `NUM_REGS` first, then register 0 and the registers above it, until the master answers with NACK.
- R7: Bytes are shifted most significant bit first in both directions. A single-byte read returns the value last written.
- R8: Bits 7:3 of register 1 read back the `strap_i` value captured while `rst` was high, and writes never change them. Bits 2:0 of register 1 are writable.
- R9: Register 8 always reads 0x08, and writes to it have no effect.
- R10: A one-cycle pulse on `stat_evt_i` sets bit 2 of register 9. Writing a byte with bit 2 = 1 clears the flag. Writing a byte with bit 2 = 0 leaves it set.
- R11: Writes to offsets at or above `NUM_REGS` are acknowledged but raise no strobe. Reads from those offsets return 0x00.
- R12: After reset the slave releases the data line and every writable register bit reads 0. The open-drain enable only asserts while the synchronised bus clock is low, and it is released after a stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst | input | 1 | Synchronous active-high reset; straps are captured while high |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_oe_o | output | 1 | 1 pulls the data line low (open drain) |
| strap_i | input | 5 | Strap levels captured into register 1 during reset |
| stat_evt_i | input | 1 | One-cycle event that sets the status flag in register 9 |
| wr_stb_o | output | 1 | One-cycle pulse for each write to an implemented register |
| wr_idx_o | output | 7 | Register index of the current write strobe |
| wr_data_o | output | 8 | Data byte of the current write strobe |
| cfg_o | output | NUM_REGS*8 | Read view of all registers; register i sits in bits 8i+7:8i |

## Verification
The assertions assume a master that never changes SDA and SCL together and keeps each bus phase much longer than the three-cycle synchroniser latency. Under that assumption, every slave change to the data line follows a detected SCL fall. The bench master holds each quarter bit period for ten system clocks and moves SDA only while SCL is low, except when it deliberately forms start and stop conditions. It also never pulls the data line low during a slave transmit, so the open-drain wired-AND never resolves a conflict that would break the assumption on release after stop.

// File: rtl/smb_pkg.sv
`timescale 1ns/1ps
package smb_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_RX,
    S_ACKTX,
    S_TX,
    S_ACKRX
  } bus_st_t;

  typedef enum logic [1:0] {
    PH_ADDR,
    PH_CMD,
    PH_CNT,
    PH_DATA
  } byte_ph_t;
endpackage

// File: rtl/smb_sync.sv
`timescale 1ns/1ps
module smb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic [STAGES-1:0] scl_sh, sda_sh;
  logic scl_d, sda_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[STAGES-2:0], scl_i};
      sda_sh <= {sda_sh[STAGES-2:0], sda_i};
      scl_d  <= scl_sh[STAGES-1];
      sda_d  <= sda_sh[STAGES-1];
    end
  end

  assign scl_s     = scl_sh[STAGES-1];
  assign sda_s     = sda_sh[STAGES-1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  // data edges only count while the clock is high on both samples
  assign start_evt = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_evt  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/smb_regfile.sv
`timescale 1ns/1ps
module smb_regfile #(
  parameter int          NUM_REGS  = 16,
  parameter int          STRAP_OFF = 1,
  parameter int          ID_OFF    = 8,
  parameter logic [7:0]  ID_BYTE   = 8'h08,
  parameter int          STAT_OFF  = 9,
  parameter int          STAT_BIT  = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  we,
  input  logic [6:0]            widx,
  input  logic [7:0]            wdata,
  input  logic [4:0]            strap_i,
  input  logic                  stat_evt,
  input  logic [6:0]            ridx,
  output logic [7:0]            rdata,
  output logic [NUM_REGS*8-1:0] cfg
);
  localparam int         IW    = $clog2(NUM_REGS);
  localparam logic [6:0] NREG7 = 7'(NUM_REGS);

  logic [7:0] view [NUM_REGS];

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    localparam logic [6:0] IDX = 7'(i);
    if (i == ID_OFF) begin : g_id
      assign view[i] = ID_BYTE;
    end else if (i == STRAP_OFF) begin : g_strap
      logic [4:0] sq;
      logic [2:0] q;
      always_ff @(posedge clk) begin
        if (rst) begin
          sq <= strap_i;
          q  <= '0;
        end else if (we && widx == IDX) begin
          q  <= wdata[2:0];
        end
      end
      assign view[i] = {sq, q};
    end else if (i == STAT_OFF) begin : g_stat
      logic [7:0] q;
      always_ff @(posedge clk) begin
        if (rst) begin
          q <= '0;
        end else begin
          for (int b = 0; b < 8; b++) begin
            if (b == STAT_BIT) begin
              if (stat_evt) q[b] <= 1'b1;
              else if (we && widx == IDX && wdata[b]) q[b] <= 1'b0;
            end else if (we && widx == IDX) begin
              q[b] <= wdata[b];
            end
          end
        end
      end
      assign view[i] = q;
    end else begin : g_plain
      logic [7:0] q;
      always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else if (we && widx == IDX) q <= wdata;
      end
      assign view[i] = q;
    end
    assign cfg[8*i +: 8] = view[i];
  end

  assign rdata = (ridx < NREG7) ? view[ridx[IW-1:0]] : 8'h00;
endmodule

// File: rtl/smb_regbank.sv
`timescale 1ns/1ps
module smb_regbank #(
  parameter logic [6:0] DEV_ADDR  = 7'h69,
  parameter int         NUM_REGS  = 16,
  parameter int         SYNC_STG  = 2,
  parameter int         STRAP_OFF = 1,
  parameter int         ID_OFF    = 8,
  parameter logic [7:0] ID_BYTE   = 8'h08,
  parameter int         STAT_OFF  = 9,
  parameter int         STAT_BIT  = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  scl_i,
  input  logic                  sda_i,
  output logic                  sda_oe_o,
  input  logic [4:0]            strap_i,
  input  logic                  stat_evt_i,
  output logic                  wr_stb_o,
  output logic [6:0]            wr_idx_o,
  output logic [7:0]            wr_data_o,
  output logic [NUM_REGS*8-1:0] cfg_o
);
  import smb_pkg::*;

  localparam logic [6:0] NREG7 = 7'(NUM_REGS);
  localparam logic [7:0] NREG8 = 8'(NUM_REGS);

  logic scl_s, sda_s, scl_rise, scl_fall, start_evt, stop_evt;
  bus_st_t  st;
  byte_ph_t ph;
  logic [7:0] shreg, txreg, remain;
  logic [3:0] bitcnt;
  logic [6:0] ptr;
  logic       blk, cnt_pend, go_tx;
  logic [7:0] rdata, txb;
  logic [6:0] ptr_inc;

  smb_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt)
  );

  smb_regfile #(
    .NUM_REGS(NUM_REGS), .STRAP_OFF(STRAP_OFF), .ID_OFF(ID_OFF),
    .ID_BYTE(ID_BYTE), .STAT_OFF(STAT_OFF), .STAT_BIT(STAT_BIT)
  ) u_regs (
    .clk(clk), .rst(rst), .we(wr_stb_o), .widx(wr_idx_o), .wdata(wr_data_o),
    .strap_i(strap_i), .stat_evt(stat_evt_i), .ridx(ptr), .rdata(rdata),
    .cfg(cfg_o)
  );

  assign txb     = cnt_pend ? NREG8 : rdata;
  assign ptr_inc = (ptr == 7'h7f) ? ptr : ptr + 7'd1;

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IDLE; ph <= PH_ADDR; shreg <= '0; txreg <= '0; remain <= '0;
      bitcnt <= '0; ptr <= '0; blk <= 1'b0; cnt_pend <= 1'b0; go_tx <= 1'b0;
      sda_oe_o <= 1'b0; wr_stb_o <= 1'b0; wr_idx_o <= '0; wr_data_o <= '0;
    end else begin
      wr_stb_o <= 1'b0;
      if (stop_evt) begin
        st <= S_IDLE;
        sda_oe_o <= 1'b0;
      end else if (start_evt) begin
        st <= S_RX;
        ph <= PH_ADDR;
        bitcnt <= '0;
        sda_oe_o <= 1'b0;
      end else begin
        case (st)
          S_RX: begin
            if (scl_rise) begin
              shreg  <= {shreg[6:0], sda_s};
              bitcnt <= bitcnt + 4'd1;
            end else if (scl_fall && bitcnt == 4'd8) begin
              bitcnt <= '0;
              st <= S_ACKTX;
              sda_oe_o <= 1'b1;
              go_tx <= 1'b0;
              case (ph)
                PH_ADDR: begin
                  if (shreg[7:1] != DEV_ADDR) begin
                    st <= S_IDLE;
                    sda_oe_o <= 1'b0;
                  end else if (shreg[0]) begin
                    go_tx <= 1'b1;
                    cnt_pend <= blk;
                  end else begin
                    ph <= PH_CMD;
                  end
                end
                PH_CMD: begin
                  blk <= ~shreg[7];
                  ptr <= shreg[7] ? shreg[6:0] : 7'd0;
                  ph  <= shreg[7] ? PH_DATA : PH_CNT;
                end
                PH_CNT: begin
                  remain <= shreg;
                  ph <= PH_DATA;
                end
                default: begin
                  if (!blk || remain != 8'd0) begin
                    if (ptr < NREG7) begin
                      wr_stb_o  <= 1'b1;
                      wr_idx_o  <= ptr;
                      wr_data_o <= shreg;
                    end
                    ptr <= ptr_inc;
                  end
                  if (blk && remain != 8'd0) remain <= remain - 8'd1;
                end
              endcase
            end
          end
          S_ACKTX: begin
            if (scl_fall) begin
              if (go_tx) begin
                txreg <= txb; sda_oe_o <= ~txb[7]; bitcnt <= '0; st <= S_TX;
                if (cnt_pend) cnt_pend <= 1'b0;
                else ptr <= ptr_inc;
              end else begin
                sda_oe_o <= 1'b0;
                st <= S_RX;
              end
            end
          end
          S_TX: begin
            if (scl_fall) begin
              if (bitcnt == 4'd7) begin
                sda_oe_o <= 1'b0;
                st <= S_ACKRX;
              end else begin
                txreg <= {txreg[6:0], 1'b0};
                sda_oe_o <= ~txreg[6];
                bitcnt <= bitcnt + 4'd1;
              end
            end
          end
          S_ACKRX: begin
            if (scl_rise) begin
              if (sda_s) st <= S_IDLE;
            end else if (scl_fall) begin
              txreg <= txb; sda_oe_o <= ~txb[7]; bitcnt <= '0; st <= S_TX;
              if (cnt_pend) cnt_pend <= 1'b0;
              else ptr <= ptr_inc;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/smb_regbank_chk.sv
`timescale 1ns/1ps
module smb_regbank_chk #(
  parameter int NREG = 16
) (
  input logic       clk,
  input logic       rst,
  input logic       scl_s,
  input logic       stop_evt,
  input logic       sda_oe,
  input logic       wr_stb,
  input logic [6:0] wr_idx,
  input logic       stat_evt,
  input logic       stat_bit
);
  localparam logic [6:0] NREG7 = 7'(NREG);

  p_oe_scl_low_r12: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe) |-> !scl_s);

  p_stop_release_r12: assert property (@(posedge clk) disable iff (rst)
    stop_evt |=> !sda_oe);

  p_stb_in_range_r11: assert property (@(posedge clk) disable iff (rst)
    wr_stb |-> (wr_idx < NREG7));

  p_stat_set_r10: assert property (@(posedge clk) disable iff (rst)
    stat_evt |=> stat_bit);
endmodule

bind smb_regbank smb_regbank_chk #(.NREG(NUM_REGS)) u_chk (
  .clk(clk), .rst(rst), .scl_s(scl_s), .stop_evt(stop_evt),
  .sda_oe(sda_oe_o), .wr_stb(wr_stb_o), .wr_idx(wr_idx_o),
  .stat_evt(stat_evt_i), .stat_bit(cfg_o[STAT_OFF*8+STAT_BIT])
);

// File: tb/tb_smb_regbank.sv
`timescale 1ns/1ps
module tb_smb_regbank;
  localparam int         NREGS = 16;
  localparam logic [7:0] AW    = 8'hD2;
  localparam logic [7:0] AR    = 8'hD3;
  localparam logic [4:0] STRAP = 5'b10110;
  localparam int         Q     = 10;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst = 1'b1, scl_m = 1'b1, sda_m = 1'b1, stat_evt = 1'b0;
  logic sda_oe, wr_stb;
  logic [6:0] wr_idx;
  logic [7:0] wr_data;
  logic [NREGS*8-1:0] cfg;
  wire sda_line = sda_m & ~sda_oe;

  smb_regbank dut (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line), .sda_oe_o(sda_oe),
    .strap_i(STRAP), .stat_evt_i(stat_evt), .wr_stb_o(wr_stb),
    .wr_idx_o(wr_idx), .wr_data_o(wr_data), .cfg_o(cfg)
  );

  int vec = 0, miss = 0, stb_cnt = 0;
  logic [6:0] last_idx = '0;
  logic [7:0] last_dat = '0;
  logic nak_seen = 1'b0;

  always @(negedge clk) if (wr_stb) begin
    stb_cnt++; last_idx = wr_idx; last_dat = wr_data;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vec++;
    if (act !== exp) begin
      miss++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wq; repeat (Q) @(negedge clk); endtask
  task automatic m_start; sda_m = 1; wq; scl_m = 1; wq; sda_m = 0; wq; scl_m = 0; wq; endtask
  task automatic m_stop; sda_m = 0; wq; scl_m = 1; wq; sda_m = 1; wq; endtask

  task automatic m_wr(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wq; scl_m = 1; wq; wq; scl_m = 0; wq;
    end
    sda_m = 1; wq; scl_m = 1; wq; ack = !sda_line; wq; scl_m = 0; wq;
  endtask

  task automatic m_rd(input logic nack, output logic [7:0] b);
    sda_m = 1;
    for (int i = 7; i >= 0; i--) begin
      wq; scl_m = 1; wq; b[i] = sda_line; wq; scl_m = 0; wq;
    end
    sda_m = nack; wq; scl_m = 1; wq; wq; scl_m = 0; wq; sda_m = 1;
  endtask

  task automatic send(input logic [7:0] b);
    logic a;
    m_wr(b, a);
    if (!a) nak_seen = 1'b1;
  endtask

  task automatic byte_wr(input logic [6:0] off, input logic [7:0] d);
    m_start; send(AW); send({1'b1, off}); send(d); m_stop;
  endtask

  task automatic byte_rd(input logic [6:0] off, output logic [7:0] d);
    m_start; send(AW); send({1'b1, off}); m_start; send(AR); m_rd(1'b1, d); m_stop;
  endtask

  function automatic logic [7:0] rg(input int i);
    return cfg[8*i +: 8];
  endfunction

  task automatic t_reset;
    chk("R12 sda released after reset", sda_oe, 0);
    chk("R12 reg0 reset", rg(0), 0);
    chk("R8 strap captured", rg(1), {STRAP, 3'b000});
    chk("R9 id at reset", rg(8), 8'h08);
  endtask

  task automatic t_mismatch;
    int n; logic a;
    n = stb_cnt;
    m_start; m_wr(8'h44, a);
    chk("R1 foreign address nacked", a, 0);
    m_wr(8'h83, a); m_wr(8'hEE, a); m_stop;
    chk("R1 no strobe on foreign address", stb_cnt, n);
    chk("R1 reg3 untouched", rg(3), 0);
  endtask

  task automatic t_byte;
    logic [7:0] d;
    nak_seen = 0;
    byte_wr(7'd3, 8'h5A);
    chk("R1 own address acked", nak_seen, 0);
    chk("R2 reg3 written", rg(3), 8'h5A);
    chk("R2 strobe index", last_idx, 3);
    chk("R2 strobe data", last_dat, 8'h5A);
    byte_rd(7'd3, d);
    chk("R7 byte read msb first", d, 8'h5A);
  endtask

  task automatic t_word;
    logic [7:0] lo, hi;
    m_start; send(AW); send(8'h85); send(8'h11); send(8'h22); m_stop;
    chk("R3 word low", rg(5), 8'h11);
    chk("R3 word high", rg(6), 8'h22);
    m_start; send(AW); send(8'h85); m_start; send(AR);
    m_rd(1'b0, lo); m_rd(1'b1, hi); m_stop;
    chk("R3 word read low", lo, 8'h11);
    chk("R3 word read high", hi, 8'h22);
  endtask

  task automatic t_block_wr;
    m_start; send(AW); send(8'h00); send(8'd3);
    send(8'hA0); send(8'hA1); send(8'hA2); m_stop;
    chk("R4 block reg0", rg(0), 8'hA0);
    chk("R4 block reg1 low bits", rg(1), {STRAP, 3'b001});
    chk("R4 block reg2", rg(2), 8'hA2);
    m_start; send(AW); send(8'h05); send(8'd1); send(8'hC3); m_stop;
    chk("R4 offset bits ignored reg0", rg(0), 8'hC3);
    chk("R4 offset bits ignored reg5", rg(5), 8'h11);
  endtask

  task automatic t_block_limits;
    nak_seen = 0;
    m_start; send(AW); send(8'h00); send(8'd1);
    send(8'h3C); send(8'h99); send(8'h98); m_stop;
    chk("R5 excess bytes acked", nak_seen, 0);
    chk("R5 first byte kept", rg(0), 8'h3C);
    chk("R5 excess discarded reg1", rg(1), {STRAP, 3'b001});
    chk("R5 excess discarded reg2", rg(2), 8'hA2);
    m_start; send(AW); send(8'h00); send(8'd3); send(8'h77); m_stop;
    chk("R5 early stop reg0", rg(0), 8'h77);
    chk("R5 early stop reg1", rg(1), {STRAP, 3'b001});
  endtask

  task automatic t_block_rd;
    logic [7:0] c, r0, r1, r2;
    m_start; send(AW); send(8'h00); m_start; send(AR);
    m_rd(1'b0, c); m_rd(1'b0, r0); m_rd(1'b0, r1); m_rd(1'b1, r2); m_stop;
    chk("R6 count first", c, NREGS);
    chk("R6 reg0", r0, 8'h77);
    chk("R6 reg1", r1, {STRAP, 3'b001});
    chk("R6 reg2", r2, 8'hA2);
    chk("R12 released after read", sda_oe, 0);
  endtask

  task automatic t_special;
    logic [7:0] d;
    byte_wr(7'd1, 8'hFF); byte_rd(7'd1, d);
    chk("R8 strap bits read-only", d, {STRAP, 3'b111});
    byte_wr(7'd8, 8'hFF); byte_rd(7'd8, d);
    chk("R9 id read-only", d, 8'h08);
    @(negedge clk) stat_evt = 1; @(negedge clk) stat_evt = 0;
    byte_rd(7'd9, d);
    chk("R10 status set", d, 8'h04);
    byte_wr(7'd9, 8'h00); byte_rd(7'd9, d);
    chk("R10 write 0 keeps", d, 8'h04);
    byte_wr(7'd9, 8'h04); byte_rd(7'd9, d);
    chk("R10 write 1 clears", d, 8'h00);
  endtask

  task automatic t_range;
    int n; logic [7:0] d, e;
    byte_wr(7'd15, 8'h6E);
    n = stb_cnt; nak_seen = 0;
    byte_wr(7'd16, 8'h55);
    chk("R11 out of range acked", nak_seen, 0);
    chk("R11 no strobe", stb_cnt, n);
    byte_rd(7'd16, d);
    chk("R11 out of range reads zero", d, 0);
    m_start; send(AW); send(8'h8F); m_start; send(AR);
    m_rd(1'b0, d); m_rd(1'b1, e); m_stop;
    chk("R11 word at top reg", d, 8'h6E);
    chk("R11 word past top", e, 0);
  endtask

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", vec, miss);
    $finish;
  endtask

  initial begin
    repeat (6) @(negedge clk);
    rst = 0;
    repeat (4) @(negedge clk);
    t_reset;
    t_mismatch;
    t_byte;
    t_word;
    t_block_wr;
    t_block_limits;
    t_block_rd;
    t_special;
    t_range;
    finish_run;
  end

  initial begin
    repeat (150000) @(posedge clk);
    miss++;
    $display("FAIL R12 watchdog actual=running expected=finished");
    finish_run;
  end
endmodule